// File: doc/BRIEF.md
# Serial Master with Automatic Chip-Select Framing

This block is a synchronous serial master. It moves one data word at a time and generates its own serial clock. In every transfer it shifts a word out on the transmit line and, in the same bit periods, shifts a word in from the receive line. Both directions always run, whether or not the data on either line means anything. The half-bit period is a programmable number of system clocks, and the idle level of the serial clock is selectable.

Four active-low chip-select lines frame each transfer. A select mask is captured when the transfer starts, and a mask bit of 0 drives its line low. Each selected line goes low half a bit before the first data bit and goes high half a bit after the last bit. The one exception is a back-to-back chained transfer, where the lines simply stay low. While the block is disabled, every internal output rests at logic 1. Each pin is the AND of that internal level with a per-pin port latch bit supplied from outside.

Top module: `sermst_cs`

## Requirements
- R1: A transfer shifts `tx_word` out on the transmit line MSB first, one bit per bit period, and at the same time shifts in `DATA_W` receive bits, first sampled bit in the MSB. The assembled word is on `rx_word` in the cycle where `done` is high. `rx_word` is 0 after reset.
- R2: Let H be `half_len`, with 0 treated as 1. If `start` is sampled at clock edge t0 while the block is enabled and idle, `done` is high for exactly one cycle: the cycle that follows edge t0 + H + 2·H·DATA_W.
- R3: A bit period is H cycles with the serial clock at its active level (the inverse of `cpol`), followed by H cycles at the idle level `cpol`. The receive line is sampled on the system clock edge that ends the active half.
- R4: Chip-select line i is low for the whole framed transfer when bit i of the `cs_sel` value captured at start is 0, and stays high when that bit is 1. The captured mask does not change while a transfer is running.
- R5: The selected chip-select lines go low H cycles before the first active clock half, and the transmit line is high during that lead time.
- R6: After the last bit period, the chip-select lines stay low for H more cycles (the first of these is the `done` cycle) and are then released. During this lag the transmit line holds the last bit.
- R7: If `start` is high with `cont` = 1 in the `done` cycle, the next cycle begins bit 0 of the new `tx_word`. There is no lead time, and the chip-select lines stay low throughout.
- R8: `start` has no effect while a transfer is running, including a `start` with `cont` = 0 in the `done` cycle. It also has no effect while `en` is 0.
- R9: While `en` is 0, every internal output is 1, so each pin equals its port latch bit. While enabled and idle, the internal clock output is `cpol`, the transmit output is 1 and the chip selects are 1. Every pin is always its internal output ANDed with its latch bit.
- R10: Dropping `en` during a transfer abandons it. The block returns to idle and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable |
| cpol | input | 1 | Serial clock idle level |
| cont | input | 1 | Allow chaining of the next word in the done cycle |
| cs_sel | input | NCS | Chip-select mask, 0 selects the line |
| half_len | input | CNT_W | System clocks per half bit (0 acts as 1) |
| tx_word | input | DATA_W | Word to transmit |
| start | input | 1 | Start strobe |
| miso | input | 1 | Serial receive line |
| latch_sclk | input | 1 | Port latch bit for the clock pin |
| latch_mosi | input | 1 | Port latch bit for the transmit pin |
| latch_cs | input | NCS | Port latch bits for the chip-select pins |
| sclk_pin | output | 1 | Serial clock pin |
| mosi_pin | output | 1 | Serial transmit pin |
| cs_n_pin | output | NCS | Chip-select pins, active low |
| rx_word | output | DATA_W | Last received word |
| done | output | 1 | One-cycle transfer completion pulse |

## Verification
The bench builds the block with DATA_W = 8, NCS = 4 and CNT_W = 4. With these values it can drive half-bit lengths of 0 (which acts as 1), 1, 2 and 3, and so reaches the single-cycle half period as well as longer ones. The four-line mask lets it try all-selected, none-in-between and mixed chip-select patterns. Both clock polarities are used, together with chained words, aborted transfers and partly cleared port latches.

// File: rtl/sermst_pkg.sv
// Shared types for the serial master.
// Assumes nothing beyond the encoding listed here.
package sermst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_BITA = 3'd2,
        ST_BITB = 3'd3,
        ST_LAG  = 3'd4
    } sm_state_t;

endpackage

// File: rtl/sermst_halfcnt.sv
// Half-bit timer. It counts system clocks while run is high and flags
// the last cycle of each half period.
// Assumes half_len is held constant while run is high. A value of 0 acts as 1.
module sermst_halfcnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] half_len,
    output logic             last
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;

    // Terminal count of one half period.
    always_comb begin
        lim_m1 = (half_len == '0) ? '0 : half_len - CNT_W'(1);
        last   = run && (cnt == lim_m1);
    end

    // Advance the counter, or restart it at each half-period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || clr || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    a_r2_half_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= lim_m1));

endmodule

// File: rtl/sermst_shift.sv
// Transmit and receive shift registers. The transmit side shifts MSB
// first. The receive side fills from the LSB, so the first bit sampled
// ends up in the MSB.
// Assumes that load, shift_out and sample never coincide.
module sermst_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              shift_out,
    input  logic              sample,
    input  logic              miso,
    input  logic              commit,
    output logic              tx_msb,
    output logic [DATA_W-1:0] rx_word
);

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;

    assign tx_msb = tx_sh[DATA_W-1];

    // Load or advance the outgoing word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '1;
        end else if (load) begin
            tx_sh <= tx_word;
        end else if (shift_out) begin
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
        end
    end

    // Collect incoming bits on each trailing clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0;
        end else if (sample) begin
            rx_sh <= {rx_sh[DATA_W-2:0], miso};
        end
    end

    // Publish the completed received word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (commit) begin
            rx_word <= rx_sh;
        end
    end

    a_r1_tx_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tx_msb == $past(tx_word[DATA_W-1])));

endmodule

// File: rtl/sermst_seq.sv
// Transfer sequencer. It runs the phases lead, active half, idle half
// (once per bit) and lag, and it decides when a chained start is taken.
// Assumes the half-bit timer's last flag is qualified by its run input.
module sermst_seq
    import sermst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      cont,
    input  logic      start,
    input  logic      last,
    output sm_state_t state,
    output logic      done,
    output logic      run,
    output logic      clr,
    output logic      capture,
    output logic      load,
    output logic      shift_out,
    output logic      sample,
    output logic      commit
);

    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    sm_state_t        nxt;
    logic [BIT_W-1:0] bit_idx;
    logic             final_bit;
    logic             go;
    logic             chain;

    // Decode the start conditions and the per-phase strobes.
    always_comb begin
        final_bit = (bit_idx == BIT_W'(DATA_W - 1));
        go        = en && start && (state == ST_IDLE);
        chain     = en && start && cont && done && (state == ST_LAG);
        run       = en && (state != ST_IDLE);
        clr       = chain;
        capture   = go;
        load      = go || chain;
        sample    = en && (state == ST_BITA) && last;
        shift_out = en && (state == ST_BITB) && last && !final_bit;
        commit    = en && (state == ST_BITB) && last && final_bit;
    end

    // Next-phase selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (go)   nxt = ST_LEAD;
            ST_LEAD: if (last) nxt = ST_BITA;
            ST_BITA: if (last) nxt = ST_BITB;
            ST_BITB: if (last) nxt = final_bit ? ST_LAG : ST_BITA;
            ST_LAG: begin
                if (chain)     nxt = ST_BITA;
                else if (last) nxt = ST_IDLE;
            end
            default:           nxt = ST_IDLE;
        endcase
        if (!en) nxt = ST_IDLE;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Bit position within the current word.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || load || commit) begin
            bit_idx <= '0;
        end else if (shift_out) begin
            bit_idx <= bit_idx + BIT_W'(1);
        end
    end

    // One-cycle completion flag, high in the first lag cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= commit;
    end

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_chain_restarts_bits: assert property (@(posedge clk) disable iff (!rst_n)
        chain |=> (state == ST_BITA) && (bit_idx == '0));

    a_r8_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start && (state == ST_LEAD)) |=> (state == ST_LEAD) || (state == ST_BITA));

    a_r10_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE) && !done);

endmodule

// File: rtl/sermst_pins.sv
// Output stage. It forms the internal clock, transmit and chip-select
// levels (all 1 while disabled) and ANDs each one with its port latch bit.
// Assumes sel_q only changes while the sequencer is idle.
module sermst_pins
    import sermst_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  sm_state_t      state,
    input  logic           cpol,
    input  logic           tx_msb,
    input  logic [NCS-1:0] sel_q,
    input  logic           latch_sclk,
    input  logic           latch_mosi,
    input  logic [NCS-1:0] latch_cs,
    output logic           sclk_pin,
    output logic           mosi_pin,
    output logic [NCS-1:0] cs_n_pin
);

    logic           busy;
    logic           data_phase;
    logic           sclk_alt;
    logic           mosi_alt;
    logic [NCS-1:0] cs_alt;

    // Internal clock and transmit levels.
    always_comb begin
        busy       = (state != ST_IDLE);
        data_phase = (state == ST_BITA) || (state == ST_BITB) || (state == ST_LAG);
        sclk_alt   = !en ? 1'b1 : ((state == ST_BITA) ? ~cpol : cpol);
        mosi_alt   = !en ? 1'b1 : (data_phase ? tx_msb : 1'b1);
    end

    assign sclk_pin = sclk_alt & latch_sclk;
    assign mosi_pin = mosi_alt & latch_mosi;

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        // One chip-select line: low only while framed and selected.
        assign cs_alt[i]   = ~(en & busy & ~sel_q[i]);
        assign cs_n_pin[i] = cs_alt[i] & latch_cs[i];
    end

    a_r9_disabled_pins_follow_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (sclk_pin == latch_sclk) && (mosi_pin == latch_mosi) && (cs_n_pin == latch_cs));

    a_r4_select_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (en && busy && $past(en) && $past(busy)) |-> $stable(cs_alt));

endmodule

// File: rtl/sermst_cs.sv
// Top level of the serial master with chip-select framing. It captures
// the mask and the half-bit length at start and wires together the timer,
// the sequencer, the shift registers and the output stage.
// Assumes cpol is only changed while the block is idle.
module sermst_cs
    import sermst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NCS    = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpol,
    input  logic              cont,
    input  logic [NCS-1:0]    cs_sel,
    input  logic [CNT_W-1:0]  half_len,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              start,
    input  logic              miso,
    input  logic              latch_sclk,
    input  logic              latch_mosi,
    input  logic [NCS-1:0]    latch_cs,
    output logic              sclk_pin,
    output logic              mosi_pin,
    output logic [NCS-1:0]    cs_n_pin,
    output logic [DATA_W-1:0] rx_word,
    output logic              done
);

    sm_state_t        state;
    logic             last;
    logic             run;
    logic             clr;
    logic             capture;
    logic             load;
    logic             shift_out;
    logic             sample;
    logic             commit;
    logic             tx_msb;
    logic [NCS-1:0]   sel_q;
    logic [CNT_W-1:0] len_q;

    // Hold the mask and the period length for the duration of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '1;
            len_q <= '0;
        end else if (capture) begin
            sel_q <= cs_sel;
            len_q <= half_len;
        end
    end

    sermst_halfcnt #(.CNT_W(CNT_W)) u_halfcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clr      (clr),
        .half_len (len_q),
        .last     (last)
    );

    sermst_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cont      (cont),
        .start     (start),
        .last      (last),
        .state     (state),
        .done      (done),
        .run       (run),
        .clr       (clr),
        .capture   (capture),
        .load      (load),
        .shift_out (shift_out),
        .sample    (sample),
        .commit    (commit)
    );

    sermst_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tx_word   (tx_word),
        .shift_out (shift_out),
        .sample    (sample),
        .miso      (miso),
        .commit    (commit),
        .tx_msb    (tx_msb),
        .rx_word   (rx_word)
    );

    sermst_pins #(.NCS(NCS)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .state      (state),
        .cpol       (cpol),
        .tx_msb     (tx_msb),
        .sel_q      (sel_q),
        .latch_sclk (latch_sclk),
        .latch_mosi (latch_mosi),
        .latch_cs   (latch_cs),
        .sclk_pin   (sclk_pin),
        .mosi_pin   (mosi_pin),
        .cs_n_pin   (cs_n_pin)
    );

endmodule

// File: tb/sermst_cs_tb_top.sv
// Bench for the serial master. Each transfer is expanded, from the
// requirements, into a queue of expected per-cycle pin levels. On every
// falling clock edge one entry is taken from the queue and compared with
// the pins; an empty queue means the idle levels are expected.
module sermst_cs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 8;
    localparam int NCS = 4;
    localparam int CW  = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic          cpol;
    logic          cont;
    logic [NCS-1:0] cs_sel;
    logic [CW-1:0] half_len;
    logic [DW-1:0] tx_word;
    logic          start;
    logic          miso;
    logic          latch_sclk;
    logic          latch_mosi;
    logic [NCS-1:0] latch_cs;
    logic          sclk_pin;
    logic          mosi_pin;
    logic [NCS-1:0] cs_n_pin;
    logic [DW-1:0] rx_word;
    logic          done;

    int checks   = 0;
    int fails    = 0;
    bit finished = 1'b0;
    bit last_done;

    // Entry layout: [7] clock, [6] transmit, [5:2] chip selects, [1] done, [0] miso to drive.
    logic [7:0]    expq[$];
    logic [DW-1:0] rxq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sermst_cs #(.DATA_W(DW), .NCS(NCS), .CNT_W(CW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cpol       (cpol),
        .cont       (cont),
        .cs_sel     (cs_sel),
        .half_len   (half_len),
        .tx_word    (tx_word),
        .start      (start),
        .miso       (miso),
        .latch_sclk (latch_sclk),
        .latch_mosi (latch_mosi),
        .latch_cs   (latch_cs),
        .sclk_pin   (sclk_pin),
        .mosi_pin   (mosi_pin),
        .cs_n_pin   (cs_n_pin),
        .rx_word    (rx_word),
        .done       (done)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: compare the pins against the next expected entry.
    task automatic tick();
        logic [7:0] e;
        bit from_q;
        @(negedge clk);
        from_q = (expq.size() > 0);
        if (from_q) e = expq.pop_front();
        else if (en) e = {cpol, 1'b1, 4'hF, 1'b0, 1'b0};
        else e = 8'b1111_1100;
        check("R3", "clock pin", 32'(sclk_pin), 32'(e[7] & latch_sclk));
        check("R1", "transmit pin", 32'(mosi_pin), 32'(e[6] & latch_mosi));
        check("R4", "select pins", 32'(cs_n_pin), 32'(e[5:2] & latch_cs));
        check("R2", "done", 32'(done), 32'(e[1]));
        if (e[1] && rxq.size() > 0) check("R1", "received word", 32'(rx_word), 32'(rxq.pop_front()));
        last_done = e[1];
        if (from_q) miso = e[0];
    endtask

    // Expand one transfer into expected cycles.
    task automatic push_xfer(int h, logic [DW-1:0] w, logic [DW-1:0] r,
                             logic [NCS-1:0] sel, logic p, bit lead);
        int hh = (h == 0) ? 1 : h;
        if (lead) for (int k = 0; k < hh; k++) expq.push_back({p, 1'b1, sel, 1'b0, 1'b0});
        for (int i = DW - 1; i >= 0; i--) begin
            for (int k = 0; k < hh; k++) expq.push_back({~p, w[i], sel, 1'b0, r[i]});
            for (int k = 0; k < hh; k++) expq.push_back({p, w[i], sel, 1'b0, r[i]});
        end
        expq.push_back({p, w[0], sel, 1'b1, 1'b0});
        for (int k = 1; k < hh; k++) expq.push_back({p, w[0], sel, 1'b0, 1'b0});
        rxq.push_back(r);
    endtask

    task automatic begin_xfer(int h, logic [DW-1:0] w, logic [DW-1:0] r, logic [NCS-1:0] sel);
        half_len = CW'(h);
        tx_word  = w;
        cs_sel   = sel;
        start    = 1'b1;
        push_xfer(h, w, r, sel, cpol, 1'b1);
        tick();
        start = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() > 0) tick();
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; cpol = 1'b0; cont = 1'b0; cs_sel = '1;
        half_len = '0; tx_word = '0; start = 1'b0; miso = 1'b0;
        latch_sclk = 1'b1; latch_mosi = 1'b1; latch_cs = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state, disabled: pins follow the latches (R9), word cleared (R1).
        tick();
        check("R1", "reset received word", 32'(rx_word), 32'h0);
        // R8: start while disabled is ignored.
        start = 1'b1; tx_word = 8'h3C; tick(); start = 1'b0; tick();
        // R9: enabled idle with clock idling low.
        en = 1'b1; tick(); tick();

        // R1 R2 R3 R5 R6: single-cycle half period, one line selected.
        begin_xfer(1, 8'hA5, 8'h3C, 4'b1110);
        drain();

        // R3 with idle-high clock, longer half period, mixed mask; R8 busy start.
        cpol = 1'b1; tick();
        begin_xfer(3, 8'h81, 8'hC7, 4'b0101);
        repeat (10) tick();
        start = 1'b1; tx_word = 8'h55; tick(); start = 1'b0;
        drain();

        // R2: half length 0 acts as 1; all lines selected.
        cpol = 1'b0; tick();
        begin_xfer(0, 8'hFF, 8'h00, 4'b0000);
        // R8: start with cont = 0 in the done cycle is ignored.
        while (!last_done) tick();
        start = 1'b1; tx_word = 8'h0F; tick(); start = 1'b0;
        drain();

        // R7: chained words keep the selects low and skip the lead.
        cont = 1'b1;
        begin_xfer(2, 8'h12, 8'h5A, 4'b1001);
        while (!last_done) tick();
        tx_word = 8'hED; start = 1'b1;
        expq.delete();
        push_xfer(2, 8'hED, 8'hA5, 4'b1001, cpol, 1'b0);
        tick(); start = 1'b0;
        drain();
        cont = 1'b0;

        // R9: pins are the internal levels ANDed with partly cleared latches.
        latch_cs = 4'b0111; latch_mosi = 1'b0;
        begin_xfer(1, 8'h6B, 8'h94, 4'b0110);
        drain();
        latch_cs = '1; latch_mosi = 1'b1;

        // R10: disabling mid-transfer aborts with no done pulse.
        begin_xfer(2, 8'hC3, 8'h3C, 4'b1100);
        repeat (9) tick();
        en = 1'b0;
        expq.delete(); rxq.delete();
        repeat (4) tick();
        check("R10", "done after abort", 32'(done), 32'h0);
        en = 1'b1;
        repeat (3) tick();
        // R10: a fresh transfer after the abort runs normally.
        begin_xfer(1, 8'h2E, 8'hB1, 4'b1011);
        drain();

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule